// File: doc/BRIEF.md
# SDRAM Open Page Tracker

This block keeps a record of the row that is currently open in each bank of one SDRAM device at a time. For every bus access it works out which command the SDRAM sequencer has to issue next. There are four possible outcomes. A page hit needs no command. A closed bank needs only an activate. A bank that holds a different row needs a precharge of that bank alone. An access to another device, or a refresh or idle condition, needs a precharge of all banks. The tracker also reports which of those triggers caused the close.

A requester holds its access fields and `req_valid` until it receives a hit or an activate decision. The tracker registers each decision and holds it, with the fields that were evaluated, until the sequencer accepts it with `dec_ready`. The bank records change only on that accept, so an acknowledged command and the stored state never disagree. After a precharge the same request is evaluated again, and it then resolves to an activate.

Top module: `page_tracker`

## Requirements
- R1: After synchronous reset, `dec_valid` is 0, every bank is closed and the recorded device is cleared, so the first access to any bank gets an activate decision.
- R2: An access to a bank with no open row yields `dec_cmd`=1 (activate) with `dec_why`=0. Accepting it opens that bank, stores the row and records the device.
- R3: An access to an open bank whose row equals the stored row in every bit set in `page_mask` yields `dec_cmd`=0 (hit) with `dec_why`=0. Bits that are clear in `page_mask` are not compared.
- R4: An access to an open bank of the current device with a different masked row yields `dec_cmd`=2 (single-bank precharge) with `dec_why`=1. Accepting it closes only that bank, and the other banks stay open.
- R5: While any bank is open, an access to a device other than the recorded one yields `dec_cmd`=3 (precharge all) with `dec_why`=2. Accepting it closes every bank.
- R6: While `refresh_req` is 1 and any bank is open, the decision is `dec_cmd`=3 with `dec_why`=3, even when a request is pending. No access decision is issued while `refresh_req` stays 1, so the pending request later resolves to an activate.
- R7: With no request, `bus_idle`=1, `keep_open`=0 and at least one bank open, the decision is `dec_cmd`=3 with `dec_why`=4. When no bank is open, idle produces no decision.
- R8: With `keep_open`=1, idle periods produce no decision and the open rows survive, so a later access to a stored row is a hit.
- R9: A decision stays asserted, with all its output fields unchanged, until the cycle in which `dec_ready` is 1. It is then withdrawn in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An access is pending |
| req_dev | input | DEV_W | Device select of the access |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row (page) address of the access |
| page_mask | input | ROW_W | Row bits taking part in the hit comparison |
| refresh_req | input | 1 | The current device needs refresh service |
| bus_idle | input | 1 | The bus has no activity |
| keep_open | input | 1 | Keep rows open through idle periods |
| dec_ready | input | 1 | Sequencer accepts the held decision |
| dec_valid | output | 1 | A decision is held |
| dec_cmd | output | 2 | 0 hit, 1 activate, 2 single-bank precharge, 3 precharge all |
| dec_why | output | 3 | 0 access, 1 bank conflict, 2 device change, 3 refresh, 4 idle |
| dec_dev | output | DEV_W | Device of the decision |
| dec_bank | output | BANK_W | Bank of the decision |
| dec_row | output | ROW_W | Row of the decision |

## Verification
The hardest situation to reach from the ports is a refresh request that arrives while pages are open and an access is already waiting. The tracker must close all banks for the refresh, then stay silent for as long as the refresh level is held, and only then turn the waiting access into an activate. The stimulus first opens two banks and raises the refresh level together with a conflicting request. It accepts the close and holds the refresh for several cycles while it watches for any decision. Only after that does it release the refresh. The idle-retain case is reached in a similar way: rows are opened, a long idle period runs with the retain bit set, and then a hit on an old row shows that those rows were kept.

// File: rtl/page_track_pkg.sv
package page_track_pkg;

    typedef enum logic [1:0] {
        CMD_HIT     = 2'd0,
        CMD_ACT     = 2'd1,
        CMD_PRE_ONE = 2'd2,
        CMD_PRE_ALL = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        WHY_ACCESS   = 3'd0,
        WHY_CONFLICT = 3'd1,
        WHY_DEVICE   = 3'd2,
        WHY_REFRESH  = 3'd3,
        WHY_IDLE     = 3'd4
    } why_e;

    typedef struct packed {
        logic fire;
        cmd_e cmd;
        why_e why;
    } verdict_t;

    function automatic logic closes_every_bank(cmd_e c);
        return c == CMD_PRE_ALL;
    endfunction

endpackage

// File: rtl/pt_bank_store.sv
module pt_bank_store
    import page_track_pkg::*;
#(
    parameter int DEV_W  = 2,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    localparam int NB    = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_en,
    input  cmd_e              upd_cmd,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row,
    input  logic [DEV_W-1:0]  upd_dev,
    output logic [NB-1:0]     open_q,
    output logic [ROW_W-1:0]  page_q [NB],
    output logic [DEV_W-1:0]  cur_dev_q
);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic hit_me;
        assign hit_me = (upd_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[b] <= 1'b0;
                page_q[b] <= '0;
            end else if (upd_en) begin
                if (closes_every_bank(upd_cmd)) begin
                    open_q[b] <= 1'b0;
                end else if (hit_me && upd_cmd == CMD_ACT) begin
                    open_q[b] <= 1'b1;
                    page_q[b] <= upd_row;
                end else if (hit_me && upd_cmd == CMD_PRE_ONE) begin
                    open_q[b] <= 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_dev_q <= '0;
        end else if (upd_en && upd_cmd == CMD_ACT) begin
            cur_dev_q <= upd_dev;
        end
    end

    // R2: an accepted activate opens the bank and stores the row
    assert_act_opens_R2: assert property (@(posedge clk) disable iff (rst)
        upd_en && upd_cmd == CMD_ACT |=>
            open_q[$past(upd_bank)] && page_q[$past(upd_bank)] == $past(upd_row));

    // R4: an accepted single-bank precharge closes that bank, others kept
    assert_pre_one_closes_R4: assert property (@(posedge clk) disable iff (rst)
        upd_en && upd_cmd == CMD_PRE_ONE |=>
            !open_q[$past(upd_bank)] &&
            ((open_q | (NB'(1) << $past(upd_bank))) == ($past(open_q) | (NB'(1) << $past(upd_bank)))));

    // R5: an accepted precharge-all leaves no bank open
    assert_pre_all_clears_R5: assert property (@(posedge clk) disable iff (rst)
        upd_en && upd_cmd == CMD_PRE_ALL |=> open_q == '0);

endmodule

// File: rtl/pt_judge.sv
module pt_judge
    import page_track_pkg::*;
#(
    parameter int DEV_W  = 2,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    localparam int NB    = 1 << BANK_W
) (
    input  logic              refresh_req,
    input  logic              req_valid,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [ROW_W-1:0]  page_mask,
    input  logic              bus_idle,
    input  logic              keep_open,
    input  logic [NB-1:0]     open_q,
    input  logic [ROW_W-1:0]  page_q [NB],
    input  logic [DEV_W-1:0]  cur_dev_q,
    output verdict_t          verdict
);

    logic any_open;
    logic bank_open;
    logic same_page;
    logic other_dev;

    assign any_open  = |open_q;
    assign bank_open = open_q[req_bank];
    assign same_page = ((req_row ^ page_q[req_bank]) & page_mask) == '0;
    assign other_dev = any_open && (req_dev != cur_dev_q);

    always_comb begin
        verdict.fire = 1'b0;
        verdict.cmd  = CMD_HIT;
        verdict.why  = WHY_ACCESS;
        if (refresh_req) begin
            if (any_open) begin
                verdict.fire = 1'b1;
                verdict.cmd  = CMD_PRE_ALL;
                verdict.why  = WHY_REFRESH;
            end
        end else if (req_valid) begin
            verdict.fire = 1'b1;
            if (other_dev) begin
                verdict.cmd = CMD_PRE_ALL;
                verdict.why = WHY_DEVICE;
            end else if (bank_open && same_page) begin
                verdict.cmd = CMD_HIT;
            end else if (bank_open) begin
                verdict.cmd = CMD_PRE_ONE;
                verdict.why = WHY_CONFLICT;
            end else begin
                verdict.cmd = CMD_ACT;
            end
        end else if (bus_idle && !keep_open && any_open) begin
            verdict.fire = 1'b1;
            verdict.cmd  = CMD_PRE_ALL;
            verdict.why  = WHY_IDLE;
        end
    end

endmodule

// File: rtl/page_tracker.sv
module page_tracker
    import page_track_pkg::*;
#(
    parameter int DEV_W  = 2,
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    localparam int NB    = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [ROW_W-1:0]  page_mask,
    input  logic              refresh_req,
    input  logic              bus_idle,
    input  logic              keep_open,
    input  logic              dec_ready,
    output logic              dec_valid,
    output logic [1:0]        dec_cmd,
    output logic [2:0]        dec_why,
    output logic [DEV_W-1:0]  dec_dev,
    output logic [BANK_W-1:0] dec_bank,
    output logic [ROW_W-1:0]  dec_row
);

    logic [NB-1:0]    open_q;
    logic [ROW_W-1:0] page_q [NB];
    logic [DEV_W-1:0] cur_dev_q;
    verdict_t         verdict;
    cmd_e             cmd_q;
    why_e             why_q;
    logic             accept;

    assign accept = dec_valid && dec_ready;

    pt_judge #(.DEV_W(DEV_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_judge (
        .refresh_req (refresh_req),
        .req_valid   (req_valid),
        .req_dev     (req_dev),
        .req_bank    (req_bank),
        .req_row     (req_row),
        .page_mask   (page_mask),
        .bus_idle    (bus_idle),
        .keep_open   (keep_open),
        .open_q      (open_q),
        .page_q      (page_q),
        .cur_dev_q   (cur_dev_q),
        .verdict     (verdict)
    );

    pt_bank_store #(.DEV_W(DEV_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (accept),
        .upd_cmd   (cmd_q),
        .upd_bank  (dec_bank),
        .upd_row   (dec_row),
        .upd_dev   (dec_dev),
        .open_q    (open_q),
        .page_q    (page_q),
        .cur_dev_q (cur_dev_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            cmd_q     <= CMD_HIT;
            why_q     <= WHY_ACCESS;
            dec_dev   <= '0;
            dec_bank  <= '0;
            dec_row   <= '0;
        end else if (accept) begin
            dec_valid <= 1'b0;
        end else if (!dec_valid && verdict.fire) begin
            dec_valid <= 1'b1;
            cmd_q     <= verdict.cmd;
            why_q     <= verdict.why;
            dec_dev   <= req_dev;
            dec_bank  <= req_bank;
            dec_row   <= req_row;
        end
    end

    assign dec_cmd = cmd_q;
    assign dec_why = why_q;

    // R9: a held decision keeps every field until accepted
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        dec_valid && !dec_ready |=> dec_valid && $stable(dec_cmd) && $stable(dec_why)
            && $stable(dec_bank) && $stable(dec_row) && $stable(dec_dev));

    // R9: an accepted decision is withdrawn next cycle
    assert_withdraw_R9: assert property (@(posedge clk) disable iff (rst)
        accept |=> !dec_valid);

    // R3: a hit is only reported for a bank that is open
    assert_hit_open_R3: assert property (@(posedge clk) disable iff (rst)
        dec_valid && cmd_q == CMD_HIT |-> open_q[dec_bank]);

    // R6: a decision raised under refresh is a refresh precharge-all
    assert_refresh_first_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_valid) && $past(refresh_req) |-> cmd_q == CMD_PRE_ALL && why_q == WHY_REFRESH);

    // R8: no idle close while rows are retained
    assert_retain_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(dec_valid) && $past(keep_open) |-> why_q != WHY_IDLE);

endmodule

// File: tb/tb_page_tracker.sv
`timescale 1ns/1ps
module tb_page_tracker;

    localparam int DEV_W  = 2;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 13;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [DEV_W-1:0]  req_dev;
    logic [BANK_W-1:0] req_bank;
    logic [ROW_W-1:0]  req_row;
    logic [ROW_W-1:0]  page_mask;
    logic              refresh_req;
    logic              bus_idle;
    logic              keep_open;
    logic              dec_ready;
    logic              dec_valid;
    logic [1:0]        dec_cmd;
    logic [2:0]        dec_why;
    logic [DEV_W-1:0]  dec_dev;
    logic [BANK_W-1:0] dec_bank;
    logic [ROW_W-1:0]  dec_row;

    page_tracker #(.DEV_W(DEV_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dev(req_dev),
        .req_bank(req_bank), .req_row(req_row), .page_mask(page_mask),
        .refresh_req(refresh_req), .bus_idle(bus_idle), .keep_open(keep_open),
        .dec_ready(dec_ready), .dec_valid(dec_valid), .dec_cmd(dec_cmd),
        .dec_why(dec_why), .dec_dev(dec_dev), .dec_bank(dec_bank), .dec_row(dec_row)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // reference state
    bit               mv [4];
    logic [ROW_W-1:0] mp [4];
    int               md;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit any_open();
        return mv[0] | mv[1] | mv[2] | mv[3];
    endfunction

    task automatic predict(input int dev, input int bank, input logic [ROW_W-1:0] row,
                           output int cmd, output int why);
        if (any_open() && dev != md) begin cmd = 3; why = 2; end
        else if (mv[bank] && ((row ^ mp[bank]) & page_mask) == '0) begin cmd = 0; why = 0; end
        else if (mv[bank]) begin cmd = 2; why = 1; end
        else begin cmd = 1; why = 0; end
    endtask

    function automatic string tag_of(input int cmd, input int why);
        if (why == 3) return "R6";
        if (why == 4) return "R7";
        case (cmd)
            0: return "R3";
            1: return "R2";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    // wait for a decision, compare, accept, update reference
    task automatic take(input int cmd, input int why, input int bank, input string req);
        int n = 0;
        while (!dec_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk(dec_valid, req, dec_valid, 1);
        chk(dec_cmd == 2'(cmd) && dec_why == 3'(why), req, dec_cmd * 10 + dec_why, cmd * 10 + why);
        if (cmd != 3) chk(dec_bank == BANK_W'(bank), req, dec_bank, bank);
        dec_ready = 1'b1;
        @(negedge clk);
        dec_ready = 1'b0;
        case (cmd)
            1: begin mv[dec_bank] = 1; mp[dec_bank] = dec_row; md = dec_dev; end
            2: mv[dec_bank] = 0;
            3: for (int b = 0; b < 4; b++) mv[b] = 0;
            default: ;
        endcase
    endtask

    task automatic access(input int dev, input int bank, input logic [ROW_W-1:0] row,
                          output int first_cmd);
        int cmd, why;
        req_dev   = DEV_W'(dev);
        req_bank  = BANK_W'(bank);
        req_row   = row;
        req_valid = 1'b1;
        first_cmd = -1;
        for (int i = 0; i < 3; i++) begin
            predict(dev, bank, row, cmd, why);
            if (first_cmd < 0) first_cmd = cmd;
            take(cmd, why, bank, tag_of(cmd, why));
            if (cmd <= 1) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic quiet(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk(!dec_valid, req, dec_valid, 0);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int fc;
        int seed;
        rst = 1; req_valid = 0; req_dev = 0; req_bank = 0; req_row = 0;
        page_mask = '1; refresh_req = 0; bus_idle = 0; keep_open = 0; dec_ready = 0;
        md = 0;
        for (int b = 0; b < 4; b++) begin mv[b] = 0; mp[b] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: nothing pending after reset, first access activates
        chk(!dec_valid, "R1", dec_valid, 0);
        quiet(3, "R1");
        access(2, 3, 13'h0123, fc);
        chk(fc == 1, "R1", fc, 1);

        // R9: decision held while not accepted
        req_dev = 2; req_bank = 1; req_row = 13'h0044; req_valid = 1;
        @(negedge clk); @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk(dec_valid && dec_cmd == 2'd1 && dec_bank == 2'd1 && dec_row == 13'h0044,
                "R9", dec_cmd, 1);
            @(negedge clk);
        end
        take(1, 0, 1, "R9");
        req_valid = 0;
        chk(!dec_valid, "R9", dec_valid, 0);

        // R4: conflict closes only its bank; bank 3 still hits
        access(2, 1, 13'h0055, fc);
        chk(fc == 2, "R4", fc, 2);
        access(2, 3, 13'h0123, fc);
        chk(fc == 0, "R4", fc, 0);

        // R3: masked comparison
        page_mask = 13'h1FF0;
        access(2, 2, 13'h00A5, fc);
        access(2, 2, 13'h00AA, fc);
        chk(fc == 0, "R3", fc, 0);
        access(2, 2, 13'h01A5, fc);
        chk(fc == 2, "R3", fc, 2);
        page_mask = '1;

        // R5: device change closes all
        access(1, 0, 13'h0007, fc);
        chk(fc == 3, "R5", fc, 3);
        access(1, 3, 13'h0123, fc);
        chk(fc == 1, "R5", fc, 1);

        // R6: refresh beats a pending request, blocks further decisions
        access(1, 1, 13'h0011, fc);
        req_dev = 1; req_bank = 0; req_row = 13'h0999; req_valid = 1; refresh_req = 1;
        take(3, 3, 0, "R6");
        quiet(5, "R6");
        refresh_req = 0;
        access(1, 0, 13'h0999, fc);
        chk(fc == 1, "R6", fc, 1);
        refresh_req = 1;
        take(3, 3, 0, "R6");
        quiet(4, "R6");
        refresh_req = 0;

        // R7: idle without retain closes all, then stays quiet
        access(0, 2, 13'h0321, fc);
        bus_idle = 1;
        take(3, 4, 0, "R7");
        quiet(5, "R7");
        bus_idle = 0;
        access(0, 2, 13'h0321, fc);
        chk(fc == 1, "R7", fc, 1);

        // R8: retain keeps rows through idle
        keep_open = 1; bus_idle = 1;
        quiet(8, "R8");
        bus_idle = 0;
        access(0, 2, 13'h0321, fc);
        chk(fc == 0, "R8", fc, 0);
        keep_open = 0;

        // sweep: mixed devices, banks, rows and masks against reference
        seed = 32'h1234_5678;
        for (int k = 0; k < 400; k++) begin
            int d, b, r;
            seed = seed * 1103515245 + 12345;
            d = ((seed >>> 20) & 15) < 2 ? ((seed >>> 8) & 3) : md;
            b = (seed >>> 12) & 3;
            r = (seed >>> 16) & 3;
            page_mask = (k >= 200) ? 13'h1FFE : 13'h1FFF;
            access(d, b, ROW_W'(r * 13'h0101), fc);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule